// File: doc/BRIEF.md
# Slot Interrupt Steering Router

This block gathers the four level-sensitive, active-low interrupt pins of every expansion slot on a shared bus and folds them onto a small set of shared routing channels. The fold follows a fixed rotation: each slot is shifted by one channel relative to the slot before it. The last slot repeats the rotation of the slot before it, so those two slots share every channel. Pins that land on the same channel are wire-ORed, so the channel is active while any of them is asserted.

Each channel has a redirection register that names one of sixteen legacy interrupt request lines and carries an enable bit. A small register port writes and reads these registers. The block refuses a write whose target is one of the reserved line numbers. The refused write disables the channel and raises a sticky error bit. Enabled channels that point at the same line are ORed onto it. The output vector is registered and active-high.

Top module: `slot_irq_steer`

## Requirements
- R1: After synchronous reset (rst_n low at a rising edge) every channel is disabled, every target and error bit is zero, and irq_out is all zero.
- R2: Pin p of slot s (0-based; slot_int_n bit s*4+p, p=0 for the first pin) drives channel (p+s) mod 4 for slots 0 to 3.
- R3: Slot 4 (bits 19:16) uses exactly the same pin-to-channel mapping as slot 3.
- R4: A channel is active while any pin mapped to it is low; it goes inactive only when all of them are high.
- R5: A write with reg_we high at a rising edge, a legal target and reg_wdata = {enable, target[3:0]} updates the channel at reg_addr. reg_rdata combinationally returns {error, enable, target[3:0]} of the channel at reg_addr.
- R6: Line numbers 0, 1, 2, 6 and 8 are reserved. A write that names one of them leaves the stored target unchanged, clears the enable and sets the error bit, whatever the enable bit of the write.
- R7: A channel's error bit stays set through later legal writes until reset.
- R8: irq_out bit k is the OR of all enabled, active channels whose target is k; a disabled channel drives no line.
- R9: A pin change shows on irq_out after the third rising edge (two synchronizer stages plus the output register). A register write at edge e shows on irq_out after edge e+1.
- R10: irq_out bits 0, 1, 2, 6 and 8 are never driven high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slot_int_n | input | 20 | Active-low slot interrupt pins, four per slot, slot s at bits s*4+3:s*4 |
| reg_we | input | 1 | Redirection register write enable |
| reg_addr | input | 2 | Channel select for write and read |
| reg_wdata | input | 5 | Write data {enable, target[3:0]} |
| reg_rdata | output | 6 | Read data {error, enable, target[3:0]} |
| irq_out | output | 16 | Active-high registered legacy interrupt request lines |

## Verification
The bench builds the block with its default parameters: five slots, four channels, sixteen lines and two synchronizer stages. With these values the aliasing of the fifth slot onto the fourth, the full rotation table and every reserved line number are all reachable. Directed cases cover each single pin, shared pins, refused writes to every reserved number, two channels on one line and the exact latency of both paths. Random pin patterns mixed with random writes, including reserved targets, are checked against a bench model of the routing and the register file.

// File: rtl/slot_irq_pkg.sv
// Shared helpers for the slot interrupt router.
// Assumes legacy line numbers are small non-negative integers.
package slot_irq_pkg;

    // Reports whether a line number may never be a redirection target.
    function automatic logic is_reserved(input int unsigned n);
        return (n == 0) || (n == 1) || (n == 2) || (n == 6) || (n == 8);
    endfunction

endpackage

// File: rtl/irq_pin_sync.sv
// Multi-stage synchronizer for a vector of asynchronous active-low pins.
// Assumes every pin is level-sensitive, so no pulse stretching is needed.
// Reset loads the inactive (high) level into every stage.
module irq_pin_sync #(
    parameter int W      = 20,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pins_n,
    output logic [W-1:0] pins_sync_n
);
    logic [W-1:0] stage_q [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            // Shift each stage one step toward the output.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[g] <= '1;
                else if (g == 0) stage_q[g] <= pins_n;
                else stage_q[g] <= stage_q[(g == 0) ? 0 : g - 1];
            end
        end
    endgenerate

    assign pins_sync_n = stage_q[STAGES-1];
endmodule

// File: rtl/irq_pin_fold.sv
// Folds per-slot interrupt pins onto shared channels with a rotation.
// Slot s is rotated by s channels; slots past the last channel count
// reuse the rotation of slot NCHAN-1. Assumes NCHAN pins per slot.
module irq_pin_fold #(
    parameter int NSLOT = 5,
    parameter int NCHAN = 4
) (
    input  logic [NSLOT*NCHAN-1:0] pins_n,
    output logic [NCHAN-1:0]       chan_act
);
    // OR every low pin into the channel its rotation selects.
    always_comb begin
        chan_act = '0;
        for (int s = 0; s < NSLOT; s++) begin
            for (int p = 0; p < NCHAN; p++) begin
                if (!pins_n[s*NCHAN+p])
                    chan_act[(p + ((s < NCHAN) ? s : NCHAN-1)) % NCHAN] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/irq_redir_regs.sv
// Redirection registers: one target, enable and sticky error per channel.
// A write naming a reserved line keeps the old target, clears the enable
// and sets the error. Reads are combinational on the address.
module irq_redir_regs #(
    parameter int NCHAN = 4,
    parameter int IRQ_W = 4,
    localparam int AW   = $clog2(NCHAN)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        reg_we,
    input  logic [AW-1:0]               reg_addr,
    input  logic [IRQ_W:0]              reg_wdata,
    output logic [IRQ_W+1:0]            reg_rdata,
    output logic [NCHAN-1:0][IRQ_W-1:0] chan_tgt,
    output logic [NCHAN-1:0]            chan_en,
    output logic [NCHAN-1:0]            chan_err
);
    import slot_irq_pkg::*;

    logic wr_bad;
    assign wr_bad = is_reserved(int'(reg_wdata[IRQ_W-1:0]));

    // Apply writes, refusing reserved targets.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chan_tgt <= '0;
            chan_en  <= '0;
            chan_err <= '0;
        end else if (reg_we) begin
            if (wr_bad) begin
                chan_en[reg_addr]  <= 1'b0;
                chan_err[reg_addr] <= 1'b1;
            end else begin
                chan_tgt[reg_addr] <= reg_wdata[IRQ_W-1:0];
                chan_en[reg_addr]  <= reg_wdata[IRQ_W];
            end
        end
    end

    // Return the addressed channel's state.
    always_comb begin
        reg_rdata = {chan_err[reg_addr], chan_en[reg_addr], chan_tgt[reg_addr]};
    end
endmodule

// File: rtl/irq_line_steer.sv
// Steers active channels onto legacy request lines through a register.
// Several enabled channels on one line are ORed. Assumes targets are
// already legal; reserved lines are kept off by the register file.
module irq_line_steer #(
    parameter int NCHAN = 4,
    parameter int NIRQ  = 16,
    parameter int IRQ_W = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NCHAN-1:0]            chan_act,
    input  logic [NCHAN-1:0]            chan_en,
    input  logic [NCHAN-1:0][IRQ_W-1:0] chan_tgt,
    output logic [NIRQ-1:0]             irq_out
);
    logic [NIRQ-1:0] line_hit;

    // Decode every enabled, active channel onto its target line.
    always_comb begin
        line_hit = '0;
        for (int c = 0; c < NCHAN; c++) begin
            for (int k = 0; k < NIRQ; k++) begin
                if (chan_act[c] && chan_en[c] && (chan_tgt[c] == IRQ_W'(k)))
                    line_hit[k] = 1'b1;
            end
        end
    end

    // Register the line vector.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_out <= '0;
        else irq_out <= line_hit;
    end
endmodule

// File: rtl/slot_irq_steer.sv
// Top of the slot interrupt router: synchronize pins, fold them onto
// shared channels, steer channels to legacy lines per programmed target.
// Assumes NCHAN pins per slot and NIRQ = 2**IRQ_W.
module slot_irq_steer #(
    parameter int NSLOT       = 5,
    parameter int NCHAN       = 4,
    parameter int NIRQ        = 16,
    parameter int SYNC_STAGES = 2,
    localparam int IRQ_W      = $clog2(NIRQ),
    localparam int AW         = $clog2(NCHAN),
    localparam int NPIN       = NSLOT * NCHAN
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPIN-1:0]  slot_int_n,
    input  logic             reg_we,
    input  logic [AW-1:0]    reg_addr,
    input  logic [IRQ_W:0]   reg_wdata,
    output logic [IRQ_W+1:0] reg_rdata,
    output logic [NIRQ-1:0]  irq_out
);
    logic [NPIN-1:0]            pins_sync_n;
    logic [NCHAN-1:0]           chan_act;
    logic [NCHAN-1:0][IRQ_W-1:0] chan_tgt;
    logic [NCHAN-1:0]           chan_en;
    logic [NCHAN-1:0]           chan_err;

    irq_pin_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .pins_n(slot_int_n), .pins_sync_n(pins_sync_n)
    );

    irq_pin_fold #(.NSLOT(NSLOT), .NCHAN(NCHAN)) u_fold (
        .pins_n(pins_sync_n), .chan_act(chan_act)
    );

    irq_redir_regs #(.NCHAN(NCHAN), .IRQ_W(IRQ_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .chan_tgt(chan_tgt), .chan_en(chan_en), .chan_err(chan_err)
    );

    irq_line_steer #(.NCHAN(NCHAN), .NIRQ(NIRQ), .IRQ_W(IRQ_W)) u_steer (
        .clk(clk), .rst_n(rst_n), .chan_act(chan_act), .chan_en(chan_en),
        .chan_tgt(chan_tgt), .irq_out(irq_out)
    );
endmodule

// File: rtl/slot_irq_steer_chk.sv
// Property checker for the slot interrupt router, bound to the top.
// Observes register port, per-channel register state and the line vector.
module slot_irq_steer_chk #(
    parameter int NCHAN = 4,
    parameter int NIRQ  = 16,
    parameter int IRQ_W = 4,
    parameter int AW    = 2
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        reg_we,
    input logic [AW-1:0]               reg_addr,
    input logic [IRQ_W:0]              reg_wdata,
    input logic [NCHAN-1:0][IRQ_W-1:0] chan_tgt,
    input logic [NCHAN-1:0]            chan_en,
    input logic [NCHAN-1:0]            chan_err,
    input logic [NIRQ-1:0]             irq_out
);
    import slot_irq_pkg::*;

    AST_IDLE_LINES_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_en == '0) |=> (irq_out == '0)); // R8

    genvar c, k;
    generate
        for (c = 0; c < NCHAN; c++) begin : g_chan
            AST_REFUSE_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
                (reg_we && reg_addr == AW'(c) && is_reserved(int'(reg_wdata[IRQ_W-1:0])))
                |=> (chan_err[c] && !chan_en[c])); // R6
            AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
                chan_err[c] |=> chan_err[c]); // R7
            AST_NO_RESERVED_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
                !(chan_en[c] && is_reserved(int'(chan_tgt[c])))); // R6
        end
        for (k = 0; k < NIRQ; k++) begin : g_line
            if (is_reserved(k)) begin : g_res
                AST_RESERVED_LINE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
                    !irq_out[k]); // R10
            end
        end
    endgenerate
endmodule

bind slot_irq_steer slot_irq_steer_chk #(
    .NCHAN(NCHAN), .NIRQ(NIRQ), .IRQ_W(IRQ_W), .AW(AW)
) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .chan_tgt(chan_tgt), .chan_en(chan_en),
    .chan_err(chan_err), .irq_out(irq_out)
);

// File: tb/slot_irq_steer_test.sv
module slot_irq_steer_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [19:0] slot_int_n = '1;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [4:0]  reg_wdata = '0;
    logic [5:0]  reg_rdata;
    logic [15:0] irq_out;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [3:0] m_tgt [4];
    logic       m_en  [4];
    logic       m_err [4];

    slot_irq_steer uut (
        .clk(clk), .rst_n(rst_n), .slot_int_n(slot_int_n), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_out(irq_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic bit bad_line(input int n);
        return n == 0 || n == 1 || n == 2 || n == 6 || n == 8;
    endfunction

    function automatic logic [15:0] model_out(input logic [19:0] pins);
        logic [3:0] act = '0;
        logic [15:0] o = '0;
        for (int s = 0; s < 5; s++)
            for (int p = 0; p < 4; p++)
                if (!pins[s*4+p]) act[(p + (s > 3 ? 3 : s)) % 4] = 1'b1;
        for (int c = 0; c < 4; c++)
            if (act[c] && m_en[c]) o[m_tgt[c]] = 1'b1;
        return o;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int ch, input bit en, input int tgt);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 2'(ch); reg_wdata = {en, 4'(tgt)};
        @(negedge clk);
        reg_we = 1'b0;
        if (bad_line(tgt)) begin m_en[ch] = 1'b0; m_err[ch] = 1'b1; end
        else begin m_tgt[ch] = 4'(tgt); m_en[ch] = en; end
    endtask

    task automatic rd_chk(input string req, input int ch);
        reg_addr = 2'(ch);
        #1;
        chk(req, 32'(reg_rdata), 32'({m_err[ch], m_en[ch], m_tgt[ch]}));
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=expired expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < 4; c++) begin m_tgt[c] = 0; m_en[c] = 0; m_err[c] = 0; end
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 out after reset", 32'(irq_out), 0);
        for (int c = 0; c < 4; c++) rd_chk("R1 regs after reset", c);

        wr(0, 1, 5); wr(1, 1, 9); wr(2, 1, 10); wr(3, 1, 11);
        for (int c = 0; c < 4; c++) rd_chk("R5 readback", c);

        // R2 / R3: each single pin lands on its rotated channel.
        for (int s = 0; s < 5; s++)
            for (int p = 0; p < 4; p++) begin
                slot_int_n = '1; slot_int_n[s*4+p] = 1'b0;
                settle();
                chk(s == 4 ? "R3 alias slot" : "R2 rotation", 32'(irq_out),
                    32'(16'(1) << m_tgt[(p + (s > 3 ? 3 : s)) % 4]));
            end
        slot_int_n = '1; settle();

        // R9: pin latency is three rising edges.
        @(negedge clk); slot_int_n[0] = 1'b0;
        @(negedge clk); chk("R9 pin edge1", 32'(irq_out), 0);
        @(negedge clk); chk("R9 pin edge2", 32'(irq_out), 0);
        @(negedge clk); chk("R9 pin edge3", 32'(irq_out), 32'(16'h0020));

        // R9: write latency, old target held for one edge.
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 2'd0; reg_wdata = {1'b1, 4'd7};
        @(negedge clk); reg_we = 1'b0; m_tgt[0] = 4'd7;
        chk("R9 write edge e", 32'(irq_out), 32'(16'h0020));
        @(negedge clk); chk("R9 write edge e+1", 32'(irq_out), 32'(16'h0080));

        // R4: two pins sharing channel 0.
        slot_int_n = '1; slot_int_n[0] = 1'b0; slot_int_n[7] = 1'b0; settle();
        chk("R4 both", 32'(irq_out), 32'(16'h0080));
        slot_int_n[0] = 1'b1; settle();
        chk("R4 one left", 32'(irq_out), 32'(16'h0080));
        slot_int_n[7] = 1'b1; settle();
        chk("R4 none", 32'(irq_out), 0);

        // R6: refused reserved target on channel 1, all reserved numbers on channel 2.
        wr(1, 1, 6);
        rd_chk("R6 refused keeps target", 1);
        slot_int_n = '1; slot_int_n[1] = 1'b0; settle();
        chk("R6 refused channel quiet", 32'(irq_out), 0);
        foreach (m_tgt[i]) if (0) ;
        for (int i = 0; i < 5; i++) begin
            int r;
            r = (i == 3) ? 6 : (i == 4) ? 8 : i;
            wr(2, 1, 10);
            wr(2, (i % 2) == 0, r);
            rd_chk("R6 reserved number", 2);
        end

        // R10: all pins low, reserved lines stay low.
        slot_int_n = '0; settle();
        chk("R10 reserved lines", 32'(irq_out & 16'h0147), 0);

        // R7: error survives a legal write.
        wr(1, 1, 12);
        rd_chk("R7 sticky error", 1);

        // R8: two channels sharing one line, then one disabled.
        wr(2, 1, 14); wr(3, 1, 14);
        slot_int_n = '1; slot_int_n[2] = 1'b0; settle();
        chk("R8 ch2 to shared", 32'(irq_out), 32'(16'h4000));
        slot_int_n = '1; slot_int_n[3] = 1'b0; settle();
        chk("R8 ch3 to shared", 32'(irq_out), 32'(16'h4000));
        wr(3, 0, 14); settle();
        chk("R8 disabled ch3", 32'(irq_out), 0);

        // Random mix of writes and pin patterns.
        for (int n = 0; n < 300; n++) begin
            if ($urandom_range(0, 2) == 0)
                wr($urandom_range(0, 3), 1'($urandom_range(0, 3) != 0), $urandom_range(0, 15));
            slot_int_n = 20'($urandom) | 20'($urandom);
            settle();
            chk("R8 random", 32'(irq_out), 32'(model_out(slot_int_n)));
            rd_chk("R5 random readback", $urandom_range(0, 3));
        end

        // R1: reset again clears everything.
        @(negedge clk); rst_n = 1'b0; slot_int_n = '0;
        @(negedge clk); rst_n = 1'b1;
        for (int c = 0; c < 4; c++) begin m_tgt[c] = 0; m_en[c] = 0; m_err[c] = 0; end
        chk("R1 out after second reset", 32'(irq_out), 0);
        for (int c = 0; c < 4; c++) rd_chk("R1 regs after second reset", c);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule